// File: doc/BRIEF.md
# Chained Control-Word Data Channel

This block moves 36-bit words between a peripheral and memory under the direction of a list of control words that software leaves in memory. Software (or a device controller) hands the channel the address of the first control word and a direction. From then on the peripheral asks for one word at a time. The channel works through the list by itself. A command word gives a block length, held as a negative count, and a starting address. A jump word redirects the list to another location. A jump that points at nothing, or at itself, closes the list.

When the list closes, or a memory error stops it, the channel writes a completion word. This word holds the final list pointer and data address, and goes into the location just after the first control word. The channel then drops busy and raises an interrupt. Software can also ask for the completion word in the middle of a transfer, and the transfer goes on afterwards.

A mode input picks how a control word is divided. The narrow mode uses an 18-bit count and an 18-bit address. The wide mode uses a 14-bit count and a 22-bit address. The mode is captured at each start.

Top module: `dma_chain_channel`

## Requirements
- R1: A start pulse (`startValid` while idle) captures the start address as the list pointer and as the completion base. It also captures the mode and the direction, clears the word count, sets busy (status bit 4), and clears the control-word-written bit (status bit 5), the error bit and the interrupt.
- R2: After reset, `status`, `irq`, `devReady` and `devAck` are all zero.
- R3: In narrow mode (`wideMode`=0) the count field is word bits 35:18 and the address field is bits 17:0. In wide mode the count field is bits 35:22 and the address field is bits 21:0. The completion word uses the same split.
- R4: A fetched word with a zero count field and an address field that is nonzero and differs from the list pointer is a jump word. The channel loads the pointer from the address field and fetches again.
- R5: A jump word whose address field is zero, or equals the list pointer, ends the transfer without setting the error bit.
- R6: A fetched word with a nonzero count field loads the word count and the data address, and advances the list pointer by one.
- R7: A device request that finds the word count at zero first fetches a control word. Every request then adds one to the count, modulo the count width. A count of -N therefore serves exactly N words.
- R8: Before each access the data address is incremented. A read returns the memory word on `devRdData` with `devAck`. A write stores `devWrData`.
- R9: A zero data address makes the word a skip. The channel makes no memory access, the address stays zero, and `devAck` is still given.
- R10: The transfer ends with the error bit (status bit 3, parameter `NXM_POS`) set in two cases: the incremented data address is above `MEM_LIMIT`, in which case no access is made, or a memory access returns `memErr`.
- R11: At the end of a transfer the completion word is written to the start address plus one. The pointer goes in the count field, and the address field holds the data address plus one if the count is nonzero, or the data address as it is if the count is zero. After that write, busy drops and `irq` rises.
- R12: A `storeCw` pulse, while idle or waiting for the device, writes the same completion word and sets status bit 5. The transfer continues with its state unchanged.
- R13: A change of `wideMode` while busy has no effect on the running transfer.
- R14: `devReady` is low whenever a control-word fetch or a memory access is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| startValid | input | 1 | Start a transfer (used only while idle) |
| startAddr | input | 22 | Address of the first control word |
| wideMode | input | 1 | 1 selects the 14/22 split, 0 the 18/18 split |
| dirToMem | input | 1 | 1 means device words are written to memory |
| storeCw | input | 1 | Request a completion word without ending the transfer |
| devReq | input | 1 | Device asks for one word, held until devAck or busy low |
| devWrData | input | 36 | Word from the device for memory writes |
| devReady | output | 1 | Channel is waiting for a device request |
| devAck | output | 1 | One-cycle pulse: the requested word is done |
| devRdData | output | 36 | Word read from memory, valid with devAck |
| memReq | output | 1 | Memory access outstanding |
| memWe | output | 1 | Access is a write |
| memAddr | output | 22 | Memory address |
| memWdata | output | 36 | Memory write data |
| memAck | input | 1 | One-cycle access completion |
| memErr | input | 1 | Access failed (valid with memAck) |
| memRdata | input | 36 | Memory read data (valid with memAck) |
| status | output | 8 | Bit 3 error, bit 4 busy, bit 5 control word written |
| irq | output | 1 | Transfer ended, cleared by the next start |

## Verification
The assertions take some input behaviour for granted. `memAck` comes at most once per access and only while `memReq` is high. `devReq` stays high until `devAck` or until busy falls. `startValid` arrives only while the channel is idle, and `storeCw` only while it is idle or showing `devReady` with no request raised. The bench keeps to these rules. Its memory model acknowledges one cycle after it sees a request and never on two cycles in a row. Its device task waits for `devReady` before it raises a request and drops the request once the word finishes. Starts and store commands are issued only at those quiet points.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

  typedef enum logic [1:0] {
    SEL_PTR  = 2'd0,
    SEL_DATA = 2'd1,
    SEL_DONE = 2'd2
  } memSel_e;

  typedef struct packed {
    logic    ldStart;
    logic    ldCmd;
    logic    ldJump;
    logic    stepCnt;
    logic    stepAddr;
    logic    ldRd;
    memSel_e sel;
  } ctlStrobe_t;

endpackage

// File: rtl/dmach_dpath.sv
module dmach_dpath
  import dmach_pkg::*;
#(
  parameter int          WORD_W       = 36,
  parameter int          NARROW_SPLIT = 18,
  parameter int          WIDE_SPLIT   = 22,
  parameter int unsigned MEM_LIMIT    = 1048575
) (
  input  logic                  clk,
  input  logic                  rst,
  input  ctlStrobe_t            ctl,
  input  logic [WIDE_SPLIT-1:0] startAddr,
  input  logic                  wideMode,
  input  logic                  dirToMem,
  input  logic [WORD_W-1:0]     devWrData,
  input  logic [WORD_W-1:0]     memRdata,
  output logic [WIDE_SPLIT-1:0] memAddr,
  output logic [WORD_W-1:0]     memWdata,
  output logic [WORD_W-1:0]     devRdData,
  output logic                  cntZero,
  output logic                  fetchCntZero,
  output logic                  jumpEnd,
  output logic                  cdaZero,
  output logic                  overLimit,
  output logic                  writeMode
);

  localparam int ADDR_W = WIDE_SPLIT;
  localparam int CNT_W  = WORD_W - NARROW_SPLIT;
  localparam logic [ADDR_W-1:0] AMASK_N = ADDR_W'((64'd1 << NARROW_SPLIT) - 64'd1);
  localparam logic [ADDR_W-1:0] AMASK_W = '1;
  localparam logic [CNT_W-1:0]  WMASK_N = '1;
  localparam logic [CNT_W-1:0]  WMASK_W = CNT_W'((64'd1 << (WORD_W - WIDE_SPLIT)) - 64'd1);

  logic              wideQ, dirQ;
  logic [ADDR_W-1:0] initQ, ptrQ, cdaQ;
  logic [CNT_W-1:0]  wcrQ;
  logic [WORD_W-1:0] rdQ;

  logic [ADDR_W-1:0] aMask, startMasked, addrField, ptrNext, cdaNext, doneAddr, cwAddr;
  logic [CNT_W-1:0]  wMask, cntField, cwCnt;
  logic [WORD_W-1:0] doneWord;

  always_comb begin
    aMask       = wideQ ? AMASK_W : AMASK_N;
    wMask       = wideQ ? WMASK_W : WMASK_N;
    startMasked = startAddr & (wideMode ? AMASK_W : AMASK_N);
    if (wideQ) cntField = CNT_W'(memRdata >> WIDE_SPLIT) & WMASK_W;
    else       cntField = CNT_W'(memRdata >> NARROW_SPLIT);
    addrField   = ADDR_W'(memRdata) & aMask;
    ptrNext     = (ptrQ + 1'b1) & aMask;
    cdaNext     = (cdaQ + 1'b1) & aMask;
    doneAddr    = (initQ + 1'b1) & aMask;
    cwCnt       = CNT_W'(ptrQ) & wMask;
    cwAddr      = (wcrQ != '0) ? cdaNext : cdaQ;
    if (wideQ) doneWord = (WORD_W'(cwCnt) << WIDE_SPLIT)   | WORD_W'(cwAddr);
    else       doneWord = (WORD_W'(cwCnt) << NARROW_SPLIT) | WORD_W'(cwAddr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wideQ <= 1'b0;
      dirQ  <= 1'b0;
      initQ <= '0;
      ptrQ  <= '0;
      cdaQ  <= '0;
      wcrQ  <= '0;
      rdQ   <= '0;
    end else begin
      if (ctl.ldStart) begin
        wideQ <= wideMode;
        dirQ  <= dirToMem;
        initQ <= startMasked;
        ptrQ  <= startMasked;
        wcrQ  <= '0;
      end
      if (ctl.ldJump) ptrQ <= addrField;
      if (ctl.ldCmd) begin
        wcrQ <= cntField;
        cdaQ <= addrField;
        ptrQ <= ptrNext;
      end
      if (ctl.stepCnt)  wcrQ <= (wcrQ + 1'b1) & wMask;
      if (ctl.stepAddr) cdaQ <= cdaNext;
      if (ctl.ldRd)     rdQ  <= memRdata;
    end
  end

  always_comb begin
    unique case (ctl.sel)
      SEL_DATA: memAddr = cdaQ;
      SEL_DONE: memAddr = doneAddr;
      default:  memAddr = ptrQ;
    endcase
    memWdata = (ctl.sel == SEL_DONE) ? doneWord : devWrData;
  end

  assign devRdData    = rdQ;
  assign cntZero      = (wcrQ == '0);
  assign fetchCntZero = (cntField == '0);
  assign jumpEnd      = (addrField == '0) || (addrField == ptrQ);
  assign cdaZero      = (cdaQ == '0);
  assign overLimit    = 32'(cdaNext) > MEM_LIMIT;
  assign writeMode    = dirQ;

  // R1: a start leaves the word count at zero
  assert_start_clears_count_R1: assert property (@(posedge clk) disable iff (rst)
    ctl.ldStart |=> cntZero);
  // R6: a command word leaves a nonzero count behind
  assert_cmd_loads_count_R6: assert property (@(posedge clk) disable iff (rst)
    (ctl.ldCmd && !ctl.stepCnt) |=> !cntZero);
  // R13: the captured mode holds for the whole transfer
  assert_mode_held_R13: assert property (@(posedge clk) disable iff (rst)
    !ctl.ldStart |=> $stable(wideQ));

endmodule

// File: rtl/dmach_ctrl.sv
module dmach_ctrl
  import dmach_pkg::*;
#(
  parameter int STAT_W   = 8,
  parameter int NXM_POS  = 3,
  parameter int BUSY_POS = 4,
  parameter int CWW_POS  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              startValid,
  input  logic              storeCw,
  input  logic              devReq,
  input  logic              memAck,
  input  logic              memErr,
  input  logic              cntZero,
  input  logic              fetchCntZero,
  input  logic              jumpEnd,
  input  logic              cdaZero,
  input  logic              overLimit,
  input  logic              writeMode,
  output ctlStrobe_t        ctl,
  output logic              memReq,
  output logic              memWe,
  output logic              devReady,
  output logic              devAck,
  output logic [STAT_W-1:0] status,
  output logic              irq
);

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_FETCH, S_STEP, S_XFER, S_DONE, S_STORE
  } state_e;

  state_e stateQ, stateD;
  logic   busyQ, nxmQ, cwwQ, irqQ, ackQ, retWaitQ;
  logic   ackNext, setNxm, finish, storeDone, enterStore;

  always_comb begin
    ctl        = '0;
    ctl.sel    = SEL_PTR;
    stateD     = stateQ;
    memReq     = 1'b0;
    memWe      = 1'b0;
    ackNext    = 1'b0;
    setNxm     = 1'b0;
    finish     = 1'b0;
    storeDone  = 1'b0;
    enterStore = 1'b0;
    unique case (stateQ)
      S_IDLE: begin
        if (startValid) begin
          ctl.ldStart = 1'b1;
          stateD      = S_WAIT;
        end else if (storeCw) begin
          enterStore = 1'b1;
          stateD     = S_STORE;
        end
      end
      S_WAIT: begin
        if (storeCw) begin
          enterStore = 1'b1;
          stateD     = S_STORE;
        end else if (devReq) begin
          stateD = cntZero ? S_FETCH : S_STEP;
        end
      end
      S_FETCH: begin
        memReq = 1'b1;
        if (memAck) begin
          if (memErr) begin
            setNxm = 1'b1;
            stateD = S_DONE;
          end else if (fetchCntZero) begin
            if (jumpEnd) stateD = S_DONE;
            else         ctl.ldJump = 1'b1;
          end else begin
            ctl.ldCmd = 1'b1;
            stateD    = S_STEP;
          end
        end
      end
      S_STEP: begin
        ctl.stepCnt = 1'b1;
        if (cdaZero) begin
          ackNext = 1'b1;
          stateD  = S_WAIT;
        end else if (overLimit) begin
          setNxm = 1'b1;
          stateD = S_DONE;
        end else begin
          ctl.stepAddr = 1'b1;
          stateD       = S_XFER;
        end
      end
      S_XFER: begin
        memReq  = 1'b1;
        memWe   = writeMode;
        ctl.sel = SEL_DATA;
        if (memAck) begin
          if (memErr) begin
            setNxm = 1'b1;
            stateD = S_DONE;
          end else begin
            ctl.ldRd = !writeMode;
            ackNext  = 1'b1;
            stateD   = S_WAIT;
          end
        end
      end
      S_DONE: begin
        memReq  = 1'b1;
        memWe   = 1'b1;
        ctl.sel = SEL_DONE;
        if (memAck) begin
          finish = 1'b1;
          stateD = S_IDLE;
        end
      end
      S_STORE: begin
        memReq  = 1'b1;
        memWe   = 1'b1;
        ctl.sel = SEL_DONE;
        if (memAck) begin
          storeDone = 1'b1;
          stateD    = retWaitQ ? S_WAIT : S_IDLE;
        end
      end
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ   <= S_IDLE;
      busyQ    <= 1'b0;
      nxmQ     <= 1'b0;
      cwwQ     <= 1'b0;
      irqQ     <= 1'b0;
      ackQ     <= 1'b0;
      retWaitQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      ackQ   <= ackNext;
      if (enterStore) retWaitQ <= (stateQ == S_WAIT);
      if (ctl.ldStart) begin
        busyQ <= 1'b1;
        nxmQ  <= 1'b0;
        cwwQ  <= 1'b0;
        irqQ  <= 1'b0;
      end
      if (setNxm) nxmQ <= 1'b1;
      if (storeDone) cwwQ <= 1'b1;
      if (finish) begin
        busyQ <= 1'b0;
        irqQ  <= 1'b1;
      end
    end
  end

  always_comb begin
    status           = '0;
    status[NXM_POS]  = nxmQ;
    status[BUSY_POS] = busyQ;
    status[CWW_POS]  = cwwQ;
  end

  assign devReady = (stateQ == S_WAIT);
  assign devAck   = ackQ;
  assign irq      = irqQ;

  // R1: start from idle sets busy and clears written/irq flags
  assert_start_sets_busy_R1: assert property (@(posedge clk) disable iff (rst)
    (stateQ == S_IDLE && startValid) |=> busyQ && !cwwQ && !irqQ && !nxmQ);
  // R14: device side is held off while memory is in use
  assert_ready_low_when_pending_R14: assert property (@(posedge clk) disable iff (rst)
    memReq |-> !devReady);
  // R11: interrupt rises only together with the end of busy
  assert_irq_with_end_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(irqQ) |-> (!busyQ && $past(busyQ)));
  // R12: written bit follows a completed memory write
  assert_cww_after_write_R12: assert property (@(posedge clk) disable iff (rst)
    $rose(cwwQ) |-> $past(memReq && memWe && memAck));
  // R10: error bit only appears while the channel is still finishing
  assert_nxm_while_busy_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(nxmQ) |-> busyQ);

endmodule

// File: rtl/dma_chain_channel.sv
module dma_chain_channel
  import dmach_pkg::*;
#(
  parameter int          WORD_W       = 36,
  parameter int          NARROW_SPLIT = 18,
  parameter int          WIDE_SPLIT   = 22,
  parameter int unsigned MEM_LIMIT    = 1048575,
  parameter int          STAT_W       = 8,
  parameter int          NXM_POS      = 3,
  parameter int          BUSY_POS     = 4,
  parameter int          CWW_POS      = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  startValid,
  input  logic [WIDE_SPLIT-1:0] startAddr,
  input  logic                  wideMode,
  input  logic                  dirToMem,
  input  logic                  storeCw,
  input  logic                  devReq,
  input  logic [WORD_W-1:0]     devWrData,
  output logic                  devReady,
  output logic                  devAck,
  output logic [WORD_W-1:0]     devRdData,
  output logic                  memReq,
  output logic                  memWe,
  output logic [WIDE_SPLIT-1:0] memAddr,
  output logic [WORD_W-1:0]     memWdata,
  input  logic                  memAck,
  input  logic                  memErr,
  input  logic [WORD_W-1:0]     memRdata,
  output logic [STAT_W-1:0]     status,
  output logic                  irq
);

  ctlStrobe_t ctl;
  logic cntZero, fetchCntZero, jumpEnd, cdaZero, overLimit, writeMode;

  dmach_ctrl #(
    .STAT_W(STAT_W), .NXM_POS(NXM_POS), .BUSY_POS(BUSY_POS), .CWW_POS(CWW_POS)
  ) u_ctrl (
    .clk(clk), .rst(rst), .startValid(startValid), .storeCw(storeCw),
    .devReq(devReq), .memAck(memAck), .memErr(memErr),
    .cntZero(cntZero), .fetchCntZero(fetchCntZero), .jumpEnd(jumpEnd),
    .cdaZero(cdaZero), .overLimit(overLimit), .writeMode(writeMode),
    .ctl(ctl), .memReq(memReq), .memWe(memWe), .devReady(devReady),
    .devAck(devAck), .status(status), .irq(irq)
  );

  dmach_dpath #(
    .WORD_W(WORD_W), .NARROW_SPLIT(NARROW_SPLIT), .WIDE_SPLIT(WIDE_SPLIT),
    .MEM_LIMIT(MEM_LIMIT)
  ) u_dpath (
    .clk(clk), .rst(rst), .ctl(ctl), .startAddr(startAddr),
    .wideMode(wideMode), .dirToMem(dirToMem), .devWrData(devWrData),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .devRdData(devRdData), .cntZero(cntZero), .fetchCntZero(fetchCntZero),
    .jumpEnd(jumpEnd), .cdaZero(cdaZero), .overLimit(overLimit),
    .writeMode(writeMode)
  );

  // R8: an outstanding access keeps its address and kind until acknowledged
  assert_req_held_R8: assert property (@(posedge clk) disable iff (rst)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe)));
  // R9: a word acknowledgement is never given with a memory access in flight
  assert_ack_without_access_R9: assert property (@(posedge clk) disable iff (rst)
    devAck |-> !memReq);

endmodule

// File: tb/dma_chain_channel_tb.sv
module dma_chain_channel_tb;

  localparam int MEM_LIMIT_TB = 1023;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        startValid = 1'b0;
  logic [21:0] startAddr = '0;
  logic        wideMode = 1'b0;
  logic        dirToMem = 1'b0;
  logic        storeCw = 1'b0;
  logic        devReq = 1'b0;
  logic [35:0] devWrData = '0;
  logic        devReady, devAck;
  logic [35:0] devRdData;
  logic        memReq, memWe;
  logic [21:0] memAddr;
  logic [35:0] memWdata;
  logic        memAck = 1'b0;
  logic        memErr = 1'b0;
  logic [35:0] memRdata = '0;
  logic [7:0]  status;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int writeCount = 0;
  logic [21:0] errAddr = 22'h3FFFFF;
  logic [35:0] mem [0:1023];
  logic [35:0] expRd[$];

  always #5 clk = ~clk;

  dma_chain_channel #(.MEM_LIMIT(MEM_LIMIT_TB)) u_dut (
    .clk(clk), .rst(rst), .startValid(startValid), .startAddr(startAddr),
    .wideMode(wideMode), .dirToMem(dirToMem), .storeCw(storeCw),
    .devReq(devReq), .devWrData(devWrData), .devReady(devReady),
    .devAck(devAck), .devRdData(devRdData), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memAck(memAck), .memErr(memErr),
    .memRdata(memRdata), .status(status), .irq(irq)
  );

  function automatic logic [35:0] cw(input bit wide, input logic [17:0] cnt,
                                     input logic [21:0] addr);
    if (wide) return {cnt[13:0], addr};
    return {cnt, addr[17:0]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [35:0] act,
                       input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model: acknowledges one cycle after seeing a request
  initial begin
    forever begin
      @(negedge clk);
      if (memReq && !memAck) begin
        memAck = 1'b1;
        memErr = (memAddr == errAddr);
        if (memWe && !memErr) begin
          mem[memAddr[9:0]] = memWdata;
          writeCount++;
        end
        memRdata = mem[memAddr[9:0]];
      end else begin
        memAck = 1'b0;
        memErr = 1'b0;
      end
    end
  end

  // scoreboard monitor for words read from memory
  initial begin
    forever begin
      @(negedge clk);
      if (devAck && !dirToMem) begin
        if (expRd.size() == 0) check(1'b0, "R8 unexpected read word", devRdData, '0);
        else begin
          logic [35:0] e;
          e = expRd.pop_front();
          check(devRdData == e, "R8 read data", devRdData, e);
        end
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      cycles++;
      if (cycles > 50000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  task automatic startXfer(input logic [21:0] a, input bit wide, input bit toMem);
    @(negedge clk);
    startAddr  = a;
    wideMode   = wide;
    dirToMem   = toMem;
    startValid = 1'b1;
    writeCount = 0;
    @(negedge clk);
    startValid = 1'b0;
  endtask

  task automatic devWord(input logic [35:0] wdata, output bit acked);
    @(negedge clk);
    while (!devReady) @(negedge clk);
    devWrData = wdata;
    devReq    = 1'b1;
    @(negedge clk);
    check(devReady == 1'b0, "R14 ready low while busy with request", devReady, 1'b0);
    while (!devAck && status[4]) @(negedge clk);
    acked  = devAck;
    devReq = 1'b0;
  endtask

  task automatic readWord(input logic [21:0] a);
    bit ok;
    expRd.push_back(mem[a[9:0]]);
    devWord('0, ok);
    check(ok, "R8 read acknowledged", 36'(ok), 36'd1);
  endtask

  task automatic waitIdle();
    while (status[4]) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    bit ok;
    for (int i = 0; i < 1024; i++) mem[i] = 36'h5_0000_0000 ^ 36'(i * 7919);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(status == 8'h00, "R2 status after reset", 36'(status), 36'h0);
    check(irq == 1'b0, "R2 irq after reset", 36'(irq), 36'h0);
    check(devReady == 1'b0 && devAck == 1'b0, "R2 device handshake idle",
          36'({devReady, devAck}), 36'h0);

    // Test 1: narrow mode read, command, jump, command, self-jump end
    mem[10'h100] = cw(0, 18'h3FFFE, 22'h200);
    mem[10'h101] = cw(0, 18'h0, 22'h120);
    mem[10'h120] = cw(0, 18'h3FFFF, 22'h300);
    mem[10'h121] = cw(0, 18'h0, 22'h121);
    startXfer(22'h100, 1'b0, 1'b0);
    check(status == 8'h10, "R1 busy set after start", 36'(status), 36'h10);
    readWord(22'h201);
    readWord(22'h202);
    readWord(22'h301);
    devWord('0, ok);
    check(!ok, "R5 self jump ends without ack", 36'(ok), 36'h0);
    waitIdle();
    check(status == 8'h00, "R5 normal end, no error bit", 36'(status), 36'h0);
    check(irq == 1'b1, "R11 irq raised at end", 36'(irq), 36'h1);
    check(mem[10'h101] == cw(0, 18'h121, 22'h301), "R11 completion word narrow",
          mem[10'h101], cw(0, 18'h121, 22'h301));

    // Test 2: wide mode write, skip word, jump to zero
    mem[10'h040] = cw(1, 18'h3FFD, 22'h1FF);
    mem[10'h041] = cw(1, 18'h3FFF, 22'h0);
    mem[10'h042] = cw(1, 18'h0, 22'h0);
    startXfer(22'h040, 1'b1, 1'b1);
    check(irq == 1'b0, "R1 start clears irq", 36'(irq), 36'h0);
    wideMode = 1'b0;   // R13: change while busy
    for (int k = 0; k < 3; k++) begin
      devWord(36'hA_5A5A_0000 + 36'(k), ok);
      check(ok, "R7 write word acknowledged", 36'(ok), 36'h1);
    end
    devWord(36'hF_FFFF_FFFF, ok);
    check(ok, "R9 skipped word still acknowledged", 36'(ok), 36'h1);
    devWord('0, ok);
    check(!ok, "R5 jump to zero ends", 36'(ok), 36'h0);
    waitIdle();
    check(mem[10'h200] == 36'hA_5A5A_0000 && mem[10'h201] == 36'hA_5A5A_0001 &&
          mem[10'h202] == 36'hA_5A5A_0002, "R3 R8 R13 wide-split write addresses",
          mem[10'h202], 36'hA_5A5A_0002);
    check(writeCount == 4, "R9 no memory access for skipped word",
          36'(writeCount), 36'd4);
    check(mem[10'h041] == cw(1, 18'h042, 22'h0), "R3 R11 completion word wide",
          mem[10'h041], cw(1, 18'h042, 22'h0));

    // Test 3: jump at head, store control word mid-transfer
    mem[10'h0A0] = cw(0, 18'h0, 22'h0B0);
    mem[10'h0A1] = '0;
    mem[10'h0B0] = cw(0, 18'h3FFFD, 22'h300);
    mem[10'h0B1] = cw(0, 18'h0, 22'h0);
    startXfer(22'h0A0, 1'b0, 1'b0);
    readWord(22'h301);
    readWord(22'h302);
    @(negedge clk);
    while (!devReady) @(negedge clk);
    storeCw = 1'b1;
    @(negedge clk);
    storeCw = 1'b0;
    while (!devReady) @(negedge clk);
    check(status == 8'h30, "R12 written bit set, still busy", 36'(status), 36'h30);
    check(mem[10'h0A1] == cw(0, 18'h0B1, 22'h303), "R12 R4 R6 mid-transfer completion",
          mem[10'h0A1], cw(0, 18'h0B1, 22'h303));
    readWord(22'h303);
    devWord('0, ok);
    check(!ok, "R7 count of -3 serves three words", 36'(ok), 36'h0);
    waitIdle();
    check(mem[10'h0A1] == cw(0, 18'h0B1, 22'h303), "R11 final completion word",
          mem[10'h0A1], cw(0, 18'h0B1, 22'h303));

    // Test 4: address above the memory limit
    mem[10'h0C0] = cw(0, 18'h3FFFE, 22'h3FE);
    startXfer(22'h0C0, 1'b0, 1'b1);
    check(status == 8'h10, "R1 start clears written bit", 36'(status), 36'h10);
    devWord(36'h1_2345_6789, ok);
    check(ok && mem[10'h3FF] == 36'h1_2345_6789, "R8 write at limit",
          mem[10'h3FF], 36'h1_2345_6789);
    devWord(36'h0_BAD0_BAD0, ok);
    check(!ok, "R10 word above limit not acknowledged", 36'(ok), 36'h0);
    waitIdle();
    check(status == 8'h08 && irq, "R10 error bit after limit", 36'(status), 36'h08);
    check(writeCount == 2, "R10 no access above limit", 36'(writeCount), 36'd2);
    check(mem[10'h0C1] == cw(0, 18'h0C1, 22'h3FF), "R10 R11 completion after limit",
          mem[10'h0C1], cw(0, 18'h0C1, 22'h3FF));

    // Test 5: memory error during a jump fetch
    errAddr = 22'h150;
    mem[10'h0D0] = cw(1, 18'h0, 22'h150);
    startXfer(22'h0D0, 1'b1, 1'b0);
    check(status == 8'h10, "R1 start clears error bit", 36'(status), 36'h10);
    devWord('0, ok);
    check(!ok, "R10 memory error ends transfer", 36'(ok), 36'h0);
    waitIdle();
    check(status == 8'h08, "R10 error bit after memory error", 36'(status), 36'h08);
    check(mem[10'h0D1] == cw(1, 18'h150, 22'h3FF), "R4 R11 completion after error",
          mem[10'h0D1], cw(1, 18'h150, 22'h3FF));

    check(expRd.size() == 0, "R8 all expected reads seen", 36'(expRd.size()), 36'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule